// File: doc/BRIEF.md
# Multi-task time-slice scheduler

This block decides, every clock cycle, which user of a shared execution datapath owns the next time slice. Eight hardware task channels and one host CPU port share that datapath. The scheduler walks a rotation of nine slots: the eight channel slots in ascending order, then one host slot that closes the round. Each cycle it issues at most one grant, as a registered one-hot vector with a valid strobe. Each channel supplies three status flags: enable, suspend and pipeline-busy. The host supplies a single access-request line.

Two policies are available. The fixed policy (state `S_FIXED`) visits every slot in turn. When a slot's channel is disabled or suspended, that slice goes to the host. The skipping policy (state `S_SKIP`) jumps straight to the next runnable channel. A channel counts as runnable when it is enabled, not suspended and not busy in the early pipeline stages. The host slot stays in the rotation under both policies, so the host is served at least once per round. The only transitions are `S_FIXED -> S_SKIP` and `S_SKIP -> S_FIXED`. Each is taken in the cycle the host slot is issued, which is the round boundary, and follows the mode select sampled in that cycle. In every other cycle the state holds.

Top module: `ts_sched`

## Requirements
- R1: A synchronous reset drives `grant` to all zeros and `grant_vld` low. It sets the state to `S_FIXED` and restarts the rotation at channel slot 0, whatever `mode_sel` is during reset.
- R2: `grant` bit k (k = 0..7) is channel k and bit 8 is the host. At most one bit is high in any cycle, and `grant_vld` is high exactly when one bit is high.
- R3: With `mode_sel` = 0 (fixed policy), successive cycles visit slots 0,1,...,7 and then the host slot, nine cycles per round. Channel k is granted in its own slot when enabled and not suspended, whatever its busy flag and the host request.
- R4: In the fixed policy, the slot of a channel that is suspended or disabled is granted to the host when `cpu_req` is high.
- R5: A slice handed to the host while `cpu_req` is low stays idle: `grant` is zero, `grant_vld` is low, and the rotation still advances by one slot.
- R6: With `mode_sel` = 1 (skipping policy), each cycle grants the lowest-numbered runnable channel at or after the current slot. Runnable means enabled, not suspended and not busy.
- R7: In the skipping policy, when no runnable channel remains before the host slot, the host slot is issued and the next round starts at slot 0. The host therefore gets one slot every round.
- R8: In the skipping policy with no runnable channel, every cycle is a host slot: the host is granted on each cycle where `cpu_req` is high, and every other cycle is idle.
- R9: A change on `mode_sel` takes effect only after the next host slot has been issued. Slots earlier in the current round keep the old policy.
- R10: Over whole rounds with steady inputs, every runnable channel receives the same number of grants, and the host receives one grant per round.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ch_en | input | 8 | Per-channel enable |
| ch_susp | input | 8 | Per-channel suspended flag |
| ch_busy | input | 8 | Per-channel flag: instruction still in early pipeline stages |
| mode_sel | input | 1 | 0 = fixed policy, 1 = skipping policy |
| cpu_req | input | 1 | Host requests datapath access |
| grant | output | 9 | One-hot slice grant; bits 0..7 channels, bit 8 host |
| grant_vld | output | 1 | High when a grant bit is set |

## Verification
A policy change and a slot hand-off can fall on the same cycle. The bench provokes this by raising `mode_sel` in the middle of a fixed round while a channel is busy. If that channel is still granted, the old policy is still in force. The new policy must then take hold only after the host slot. The other coincidence is a suspended channel's slot landing on a cycle where the host request is low. The bench checks that this cycle stays idle and that the next slot still follows in order.

// File: rtl/sched_pkg.sv
package sched_pkg;
    typedef enum logic {
        S_FIXED = 1'b0,
        S_SKIP  = 1'b1
    } sched_state_e;
endpackage

// File: rtl/sched_elig.sv
module sched_elig #(
    parameter int N_CH = 8
) (
    input  logic [N_CH-1:0] ch_en,
    input  logic [N_CH-1:0] ch_susp,
    input  logic [N_CH-1:0] ch_busy,
    output logic [N_CH-1:0] fixed_ok,
    output logic [N_CH-1:0] skip_ok
);
    // Per-channel eligibility under each policy
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        assign fixed_ok[c] = ch_en[c] & ~ch_susp[c];
        assign skip_ok[c]  = ch_en[c] & ~ch_susp[c] & ~ch_busy[c];
    end
endmodule

// File: rtl/sched_pick.sv
module sched_pick #(
    parameter int N_CH = 8,
    localparam int PW = $clog2(N_CH + 1)
) (
    input  logic [N_CH-1:0] cand,
    input  logic [PW-1:0]   start,
    output logic            found,
    output logic [PW-1:0]   idx
);
    logic [N_CH-1:0] window;

    // Keep only candidates at or after the current slot
    for (genvar c = 0; c < N_CH; c++) begin : g_win
        assign window[c] = cand[c] && (PW'(c) >= start);
    end

    // Lowest set bit of the window wins
    always_comb begin
        found = 1'b0;
        idx   = PW'(N_CH);
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (window[i]) begin
                found = 1'b1;
                idx   = PW'(i);
            end
        end
    end
endmodule

// File: rtl/ts_sched.sv
module ts_sched #(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] ch_en,
    input  logic [N_CH-1:0] ch_susp,
    input  logic [N_CH-1:0] ch_busy,
    input  logic            mode_sel,
    input  logic            cpu_req,
    output logic [N_CH:0]   grant,
    output logic            grant_vld
);
    import sched_pkg::*;

    localparam int          SLOTS     = N_CH + 1;
    localparam int          PW        = $clog2(SLOTS);
    localparam logic [PW-1:0] HOST_SLOT = PW'(N_CH);

    sched_state_e    state_q, state_nx;
    logic [PW-1:0]   slot_q, slot_nx;
    logic [N_CH-1:0] fixed_ok, skip_ok;
    logic [N_CH:0]   fixed_ext;
    logic            hit;
    logic [PW-1:0]   hit_idx;
    logic [PW-1:0]   pick_slot;
    logic            chan_take;
    logic            boundary;
    logic [N_CH:0]   grant_nx;
    logic            vld_nx;

    sched_elig #(.N_CH(N_CH)) u_elig (
        .ch_en    (ch_en),
        .ch_susp  (ch_susp),
        .ch_busy  (ch_busy),
        .fixed_ok (fixed_ok),
        .skip_ok  (skip_ok)
    );

    sched_pick #(.N_CH(N_CH)) u_pick (
        .cand  (skip_ok),
        .start (slot_q),
        .found (hit),
        .idx   (hit_idx)
    );

    // Host slot position is never a runnable channel
    assign fixed_ext = {1'b0, fixed_ok};

    // Slot choice and next state
    always_comb begin
        pick_slot = HOST_SLOT;
        chan_take = 1'b0;
        unique case (state_q)
            S_FIXED: begin
                pick_slot = slot_q;
                chan_take = fixed_ext[slot_q];
            end
            S_SKIP: begin
                pick_slot = hit ? hit_idx : HOST_SLOT;
                chan_take = hit;
            end
        endcase

        boundary = (pick_slot == HOST_SLOT);
        slot_nx  = boundary ? '0 : PW'(pick_slot + 1'b1);
        state_nx = state_q;
        if (boundary) begin
            state_nx = mode_sel ? S_SKIP : S_FIXED;
        end

        grant_nx = '0;
        if (chan_take) begin
            grant_nx = SLOTS'(1) << pick_slot;
        end else if (cpu_req) begin
            grant_nx[N_CH] = 1'b1;
        end
        vld_nx = chan_take | cpu_req;
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_FIXED;
            slot_q  <= '0;
        end else begin
            state_q <= state_nx;
            slot_q  <= slot_nx;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            grant     <= '0;
            grant_vld <= 1'b0;
        end else begin
            grant     <= grant_nx;
            grant_vld <= vld_nx;
        end
    end
endmodule

// File: rtl/ts_sched_chk.sv
module ts_sched_chk #(
    parameter int N_CH = 8
) (
    input logic            clk,
    input logic            rst,
    input logic [N_CH-1:0] ch_en,
    input logic [N_CH-1:0] ch_susp,
    input logic [N_CH-1:0] ch_busy,
    input logic            cpu_req,
    input logic            in_skip,
    input logic [N_CH:0]   grant,
    input logic            grant_vld
);
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R2

    AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (rst)
        grant_vld == (grant != '0)); // R2

    AST_HOST_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        grant[N_CH] |-> $past(cpu_req)); // R5

    AST_CH_RUNNABLE: assert property (@(posedge clk) disable iff (rst)
        grant_vld |-> ((grant[N_CH-1:0] & ~$past(ch_en & ~ch_susp)) == '0)); // R4

    AST_SKIP_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        $past(in_skip) |-> ((grant[N_CH-1:0] & $past(ch_busy)) == '0)); // R6
endmodule

bind ts_sched ts_sched_chk #(.N_CH(N_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ch_en     (ch_en),
    .ch_susp   (ch_susp),
    .ch_busy   (ch_busy),
    .cpu_req   (cpu_req),
    .in_skip   (state_q == sched_pkg::S_SKIP),
    .grant     (grant),
    .grant_vld (grant_vld)
);

// File: tb/ts_sched_bench.sv
module ts_sched_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] ch_en = 8'h00;
    logic [7:0] ch_susp = 8'h00;
    logic [7:0] ch_busy = 8'h00;
    logic       mode_sel = 1'b0;
    logic       cpu_req = 1'b0;
    logic [8:0] grant;
    logic       grant_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ts_sched u_ts_sched (
        .clk       (clk),
        .rst       (rst),
        .ch_en     (ch_en),
        .ch_susp   (ch_susp),
        .ch_busy   (ch_busy),
        .mode_sel  (mode_sel),
        .cpu_req   (cpu_req),
        .grant     (grant),
        .grant_vld (grant_vld)
    );

    // {en, susp, busy, mode, cpu, expected grant, expected valid}
    localparam logic [35:0] TBL [19] = '{
        {8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 9'h001, 1'b1},
        {8'hFF, 8'h02, 8'h00, 1'b0, 1'b1, 9'h100, 1'b1},
        {8'hFB, 8'h00, 8'h00, 1'b0, 1'b0, 9'h000, 1'b0},
        {8'hFF, 8'h00, 8'h08, 1'b0, 1'b0, 9'h008, 1'b1},
        {8'hFF, 8'h00, 8'h00, 1'b0, 1'b1, 9'h010, 1'b1},
        {8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 9'h020, 1'b1},
        {8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 9'h040, 1'b1},
        {8'hFF, 8'h80, 8'h00, 1'b0, 1'b0, 9'h000, 1'b0},
        {8'hFF, 8'h00, 8'h00, 1'b0, 1'b1, 9'h100, 1'b1},
        {8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 9'h001, 1'b1},
        {8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 9'h002, 1'b1},
        {8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 9'h004, 1'b1},
        {8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 9'h008, 1'b1},
        {8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 9'h010, 1'b1},
        {8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 9'h020, 1'b1},
        {8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 9'h040, 1'b1},
        {8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 9'h080, 1'b1},
        {8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 9'h000, 1'b0},
        {8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 9'h001, 1'b1}
    };

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic check(input logic [8:0] exp_g, input logic exp_v, input string tag);
        n_chk++;
        if (grant !== exp_g || grant_vld !== exp_v) begin
            n_bad++;
            $display("FAIL %s grant=%h vld=%b expected grant=%h vld=%b",
                     tag, grant, grant_vld, exp_g, exp_v);
        end
    endtask

    task automatic check_int(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a negedge: apply inputs, let one edge pass, sample at the next negedge
    task automatic step(input logic [7:0] en, input logic [7:0] su, input logic [7:0] bz,
                        input logic md, input logic cr,
                        input logic [8:0] exp_g, input logic exp_v, input string tag);
        ch_en = en; ch_susp = su; ch_busy = bz; mode_sel = md; cpu_req = cr;
        @(posedge clk);
        @(negedge clk);
        check(exp_g, exp_v, tag);
    endtask

    // Run steady inputs and count grants per bit
    task automatic run_fair(input int cycles, input logic md, input logic [7:0] su,
                            output int cnt [9], output int multi);
        for (int k = 0; k < 9; k++) cnt[k] = 0;
        multi = 0;
        ch_en = 8'hFF; ch_susp = su; ch_busy = 8'h00; mode_sel = md; cpu_req = 1'b1;
        for (int c = 0; c < cycles; c++) begin
            @(posedge clk);
            @(negedge clk);
            if ($countones(grant) > 1) multi++;
            for (int k = 0; k < 9; k++) if (grant[k]) cnt[k]++;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    initial begin
        int cnt [9];
        int multi;
        logic [35:0] v;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(9'h000, 1'b0, "R1 reset");
        rst = 1'b0;

        // Table: fixed policy from slot 0 (R3, R4, R5)
        for (int i = 0; i < 19; i++) begin
            v = TBL[i];
            step(v[35:28], v[27:20], v[19:12], v[11], v[10], v[9:1], v[0],
                 (v[0] == 1'b0) ? "R5 idle host slice" :
                 (v[9] ? "R4 host slice" : "R3 channel slot"));
        end

        // R9: mode raised mid-round (now at slot 1); busy ch2 must still be granted
        step(8'hFF, 8'h00, 8'h04, 1'b1, 1'b0, 9'h002, 1'b1, "R9 old policy slot1");
        step(8'hFF, 8'h00, 8'h04, 1'b1, 1'b0, 9'h004, 1'b1, "R9 busy ignored before boundary");
        for (int s = 3; s < 8; s++)
            step(8'hFF, 8'h00, 8'h00, 1'b1, 1'b0, 9'(1 << s), 1'b1, "R9 round completes");
        step(8'hFF, 8'h00, 8'h00, 1'b1, 1'b1, 9'h100, 1'b1, "R9 boundary host slot");

        // Skipping policy
        step(8'hFF, 8'h0E, 8'h10, 1'b1, 1'b0, 9'h001, 1'b1, "R6 first runnable");
        step(8'hFF, 8'h0E, 8'h10, 1'b1, 1'b0, 9'h020, 1'b1, "R6 skip suspended and busy");
        step(8'h7F, 8'h00, 8'h40, 1'b1, 1'b1, 9'h100, 1'b1, "R7 host closes round");
        step(8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 9'h100, 1'b1, "R8 none runnable host");
        step(8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 9'h000, 1'b0, "R8 none runnable idle");
        step(8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 9'h100, 1'b1, "R8 host again");

        // R10 / R7: skipping fairness, odd channels suspended, 20 rounds of 5 cycles
        run_fair(100, 1'b1, 8'hAA, cnt, multi);
        check_int(multi, 0, "R2 one-hot during skip run");
        for (int k = 0; k < 8; k++)
            check_int(cnt[k], (k % 2 == 0) ? 20 : 0, "R10 skip fairness");
        check_int(cnt[8], 20, "R7 host once per round");

        // R1: reset mid-run with mode_sel high, then fixed policy from slot 0
        rst = 1'b1;
        mode_sel = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(9'h000, 1'b0, "R1 reset mid-run");
        rst = 1'b0;
        step(8'hFF, 8'h00, 8'h01, 1'b1, 1'b0, 9'h001, 1'b1, "R1 fixed policy after reset");

        // R10: fixed fairness, 5 rounds from slot 1
        run_fair(45, 1'b0, 8'h00, cnt, multi);
        check_int(multi, 0, "R2 one-hot during fixed run");
        for (int k = 0; k < 9; k++)
            check_int(cnt[k], 5, "R10 fixed fairness");

        done = 1'b1;
        report();
        $finish;
    end
endmodule